// File: doc/BRIEF.md
# Move-on-Read Wiper Register Controller

This block is the register side of a two-wire serial slave that serves four digital potentiometer channels. Each channel owns an 8-bit wiper register, which sets one of 256 tap positions, and a small bank of stored data registers. The block does not see the bus pins. It works on a bus that has already been framed into START and STOP pulses, received bytes, and master acknowledge bits. It decodes two read forms. A random read carries an address byte that sets the channel and bank pointer. A current-address read uses the pointer left by earlier traffic.

Every read is a move as well. When the read header is accepted, each channel's wiper register is loaded from that channel's data register in the selected bank. The data bytes are then streamed to the master one channel after another, for as long as the master acknowledges. The channel index wraps from the last channel to the first. A master NACK ends the stream. The pointer keeps its last stepped value and is used by the next current-address read.

The stored data registers are filled through a plain write port, which stands in for the nonvolatile storage side.

Top module: `dcp_move_read`

## Requirements
- R1: After reset all wiper outputs are 0, `tx_vld` and `slv_ack` are 0, and the pointer selects channel 0, bank 0. A current-address read taken straight after reset therefore returns data register 0 of channel 0.
- R2: A byte that arrives after START is acknowledged only if its upper seven bits equal the device address (default 7'h2C). Bit 0 is R/W. If the address does not match, the block gives no acknowledge and ignores every later byte until the next START.
- R3: In a random read the address byte is acknowledged. Its bits [1:0] give the channel and bits [3:2] give the bank. After a repeated START and the device address with R/W=1 (also acknowledged), the first data byte is the data register at that channel and bank.
- R4: A current-address read (START, then the device address with R/W=1) is acknowledged and returns the data register at the stored channel and bank.
- R5: Each master ACK of a data byte advances the channel by one within the same bank, and the next data byte comes from the new channel.
- R6: Advancing from channel 3 wraps to channel 0.
- R7: When a read header is accepted, every channel's wiper register takes that channel's data register in the selected bank. This appears on `wiper_flat` within two clock cycles.
- R8: A master NACK drops `tx_vld` until the next START. The channel pointer still advances for that final byte, and the next current-address read starts from the advanced value.
- R9: A byte received after the address byte, with no repeated START in between, is not acknowledged and leaves the pointer as the address byte set it.
- R10: A STOP ends any transfer and leaves `tx_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | One-cycle pulse for START or repeated START |
| bus_stop | input | 1 | One-cycle pulse for STOP |
| rx_vld | input | 1 | One-cycle pulse: a byte from the master is complete |
| rx_data | input | 8 | Byte received from the master |
| mack_vld | input | 1 | One-cycle pulse: master acknowledge bit after a data byte |
| mack_nack | input | 1 | With `mack_vld`: 1 means NACK, 0 means ACK |
| dr_we | input | 1 | Data register write strobe |
| dr_ch | input | 2 | Channel of the data register write |
| dr_bank | input | 2 | Bank of the data register write |
| dr_wdata | input | 8 | Data register write value |
| slv_ack | output | 1 | One-cycle pulse, the cycle after `rx_vld`, when the slave acknowledges |
| tx_vld | output | 1 | High while a data byte is being offered to the master |
| tx_data | output | 8 | Data byte to shift out |
| wiper_flat | output | 32 | Wiper registers, channel c at bits [8c+7:8c] |

## Verification
A pointer that is stepped wrongly or not wrapped shows up on the next data byte. That byte appears on `tx_data` a few cycles after the master ACK, and it is compared against a per-channel, per-bank value computed in the bench. A pointer that is lost after a NACK shows on the first byte of the following current-address read. A move that loads the wrong bank, or that does not happen, shows on `wiper_flat` within two cycles of the acknowledged read header. A state machine stuck in the wrong phase shows as a missing or extra `slv_ack` pulse on the very next byte.

// File: rtl/dcp_mr_pkg.sv
package dcp_mr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_DEV,    // expecting device address
    ST_REG,    // expecting address byte
    ST_RPT,    // expecting repeated START
    ST_SEND,   // offering data bytes
    ST_HOLD    // ignoring traffic until START/STOP
  } mr_state_t;
endpackage

// File: rtl/dcp_mr_seq.sv
module dcp_mr_seq
  import dcp_mr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int NBANK = 4,
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  localparam int CHW = $clog2(NCH),
  localparam int BKW = $clog2(NBANK)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_start,
  input  logic           bus_stop,
  input  logic           rx_vld,
  input  logic [7:0]     rx_data,
  input  logic           mack_vld,
  input  logic           mack_nack,
  output logic [CHW-1:0] ptr_ch,
  output logic [BKW-1:0] ptr_bank,
  output logic           slv_ack,
  output logic           tx_vld,
  output logic           move_pulse
);
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  mr_state_t state;
  logic [CHW-1:0] ch_next;

  assign ch_next = (ptr_ch == LAST_CH) ? '0 : ptr_ch + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ptr_ch     <= '0;
      ptr_bank   <= '0;
      slv_ack    <= 1'b0;
      tx_vld     <= 1'b0;
      move_pulse <= 1'b0;
    end else begin
      slv_ack    <= 1'b0;
      move_pulse <= 1'b0;
      if (bus_stop) begin
        state  <= ST_IDLE;
        tx_vld <= 1'b0;
      end else if (bus_start) begin
        state  <= ST_DEV;
        tx_vld <= 1'b0;
      end else begin
        case (state)
          ST_DEV: if (rx_vld) begin
            if (rx_data[7:1] == DEV_ADDR) begin
              slv_ack <= 1'b1;
              if (rx_data[0]) begin
                state      <= ST_SEND;
                tx_vld     <= 1'b1;
                move_pulse <= 1'b1;
              end else begin
                state <= ST_REG;
              end
            end else begin
              state <= ST_HOLD;
            end
          end
          ST_REG: if (rx_vld) begin
            slv_ack  <= 1'b1;
            ptr_ch   <= rx_data[CHW-1:0];
            ptr_bank <= rx_data[CHW +: BKW];
            state    <= ST_RPT;
          end
          ST_RPT: if (rx_vld) state <= ST_HOLD;
          ST_SEND: if (mack_vld) begin
            ptr_ch <= ch_next;
            if (mack_nack) begin
              state  <= ST_HOLD;
              tx_vld <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dcp_mr_store.sv
module dcp_mr_store #(
  parameter int NBANK = 4,
  parameter int DW = 8,
  localparam int BKW = $clog2(NBANK)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [BKW-1:0] wbank,
  input  logic [DW-1:0]  wdata,
  input  logic [BKW-1:0] rbank,
  input  logic           move,
  output logic [DW-1:0]  rdq,
  output logic [DW-1:0]  wiper
);
  logic [DW-1:0] mem [NBANK];

  // Single write port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[wbank] <= wdata;
    rdq <= mem[rbank];
  end

  always_ff @(posedge clk) begin
    if (rst)       wiper <= '0;
    else if (move) wiper <= rdq;
  end
endmodule

// File: rtl/dcp_move_read.sv
module dcp_move_read #(
  parameter int NCH = 4,
  parameter int NBANK = 4,
  parameter int DW = 8,
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  localparam int CHW = $clog2(NCH),
  localparam int BKW = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              rx_vld,
  input  logic [7:0]        rx_data,
  input  logic              mack_vld,
  input  logic              mack_nack,
  input  logic              dr_we,
  input  logic [CHW-1:0]    dr_ch,
  input  logic [BKW-1:0]    dr_bank,
  input  logic [DW-1:0]     dr_wdata,
  output logic              slv_ack,
  output logic              tx_vld,
  output logic [DW-1:0]     tx_data,
  output logic [NCH*DW-1:0] wiper_flat
);
  logic [CHW-1:0] ptr_ch;
  logic [BKW-1:0] ptr_bank;
  logic           move_pulse;
  logic [DW-1:0]  rd_q [NCH];

  dcp_mr_seq #(.NCH(NCH), .NBANK(NBANK), .DEV_ADDR(DEV_ADDR)) u_seq (
    .clk, .rst, .bus_start, .bus_stop, .rx_vld, .rx_data,
    .mack_vld, .mack_nack, .ptr_ch, .ptr_bank, .slv_ack, .tx_vld,
    .move_pulse
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dcp_mr_store #(.NBANK(NBANK), .DW(DW)) u_store (
      .clk, .rst,
      .we    (dr_we && (dr_ch == CHW'(c))),
      .wbank (dr_bank),
      .wdata (dr_wdata),
      .rbank (ptr_bank),
      .move  (move_pulse),
      .rdq   (rd_q[c]),
      .wiper (wiper_flat[c*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) tx_data <= '0;
    else     tx_data <= rd_q[ptr_ch];
  end
endmodule

// File: rtl/dcp_move_read_chk.sv
module dcp_move_read_chk #(
  parameter int NCH = 4,
  parameter int DW = 8,
  localparam int CHW = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_start,
  input logic              bus_stop,
  input logic              rx_vld,
  input logic              mack_vld,
  input logic              mack_nack,
  input logic              slv_ack,
  input logic              tx_vld,
  input logic [CHW-1:0]    ptr_ch,
  input logic [NCH*DW-1:0] wiper_flat
);
  localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (wiper_flat == '0 && !tx_vld && !slv_ack && ptr_ch == '0));

  assert_ack_after_byte_R2: assert property (@(posedge clk) disable iff (rst)
    slv_ack |-> $past(rx_vld));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_vld && mack_vld && !mack_nack && !bus_start && !bus_stop && ptr_ch != LAST)
    |=> ptr_ch == $past(ptr_ch) + 1'b1);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_vld && mack_vld && !bus_start && !bus_stop && ptr_ch == LAST)
    |=> ptr_ch == '0);

  assert_nack_release_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_vld && mack_vld && mack_nack && !bus_start && !bus_stop) |=> !tx_vld);

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> !tx_vld);
endmodule

bind dcp_move_read dcp_move_read_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
  .rx_vld(rx_vld), .mack_vld(mack_vld), .mack_nack(mack_nack),
  .slv_ack(slv_ack), .tx_vld(tx_vld), .ptr_ch(ptr_ch), .wiper_flat(wiper_flat)
);

// File: tb/sim_dcp_move_read.sv
module sim_dcp_move_read;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES = 150000;
  localparam logic [7:0] WR_ADDR = 8'h58;
  localparam logic [7:0] RD_ADDR = 8'h59;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_start = 0, bus_stop = 0, rx_vld = 0, mack_vld = 0, mack_nack = 0;
  logic [7:0] rx_data = '0;
  logic dr_we = 0;
  logic [1:0] dr_ch = '0, dr_bank = '0;
  logic [7:0] dr_wdata = '0;
  logic slv_ack, tx_vld;
  logic [7:0] tx_data;
  logic [31:0] wiper_flat;

  logic [7:0] dr_m [4][4];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcp_move_read u0 (
    .clk, .rst, .bus_start, .bus_stop, .rx_vld, .rx_data, .mack_vld,
    .mack_nack, .dr_we, .dr_ch, .dr_bank, .dr_wdata, .slv_ack, .tx_vld,
    .tx_data, .wiper_flat
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic p_start();
    @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0; idle(3);
  endtask

  task automatic p_stop();
    @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0; idle(3);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    @(negedge clk); rx_data = b; rx_vld = 1;
    @(negedge clk); rx_vld = 0;
    chk(32'(slv_ack), 32'(exp_ack), tag);
    idle(4);
  endtask

  task automatic m_ack(input logic nack);
    @(negedge clk); mack_vld = 1; mack_nack = nack;
    @(negedge clk); mack_vld = 0; mack_nack = 0;
    idle(4);
  endtask

  task automatic load_dr(input logic [7:0] mix);
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 4; b++) begin
        dr_m[c][b] = 8'(c * 53 + b * 29 + 7) ^ mix;
        @(negedge clk);
        dr_we = 1; dr_ch = 2'(c); dr_bank = 2'(b); dr_wdata = dr_m[c][b];
      end
    @(negedge clk); dr_we = 0;
    idle(2);
  endtask

  task automatic check_wipers(input int b, input string tag);
    for (int c = 0; c < 4; c++)
      chk(32'(wiper_flat[c*8 +: 8]), 32'(dr_m[c][b]), tag);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] w_save;
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset state
    chk(wiper_flat, 32'h0, "R1 wipers");
    chk(32'(tx_vld), 0, "R1 tx_vld");
    chk(32'(slv_ack), 0, "R1 slv_ack");

    load_dr(8'h00);
    // R1: pointer starts at channel 0 bank 0
    p_start();
    send_byte(RD_ADDR, 1'b1, "R4 cur-read ack");
    chk(32'(tx_data), 32'(dr_m[0][0]), "R1 first byte from ch0 bank0");
    check_wipers(0, "R7 move bank0");
    m_ack(1'b1);
    p_stop();

    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) load_dr(8'hA5);
      for (int b = 0; b < 4; b++)
        for (int s = 0; s < 4; s++) begin
          p_start();
          send_byte(WR_ADDR, 1'b1, "R2 write addr ack");
          send_byte(8'({b[1:0], s[1:0]}), 1'b1, "R3 address byte ack");
          p_start();
          send_byte(RD_ADDR, 1'b1, "R3 read addr ack");
          check_wipers(b, "R7 move");
          for (int k = 0; k < 5; k++) begin
            chk(32'(tx_vld), 1, "R5 tx_vld during stream");
            chk(32'(tx_data), 32'(dr_m[(s + k) % 4][b]),
                k == 0 ? "R3 first byte" : ((s + k) % 4 == 0 ? "R6 wrap byte" : "R5 step byte"));
            m_ack(k == 4);
          end
          chk(32'(tx_vld), 0, "R8 released after nack");
          p_stop();
          chk(32'(tx_vld), 0, "R10 idle after stop");
          // R8 pointer kept; R4 current read uses it
          p_start();
          send_byte(RD_ADDR, 1'b1, "R4 cur-read ack");
          chk(32'(tx_data), 32'(dr_m[(s + 5) % 4][b]), "R8 pointer after nack");
          m_ack(1'b1);
          p_stop();
        end
    end

    // R2: wrong device address, then bytes ignored until START
    w_save = wiper_flat;
    p_start();
    send_byte(8'h5B, 1'b0, "R2 mismatch no ack");
    chk(32'(tx_vld), 0, "R2 no stream on mismatch");
    send_byte(RD_ADDR, 1'b0, "R2 ignored until start");
    chk(32'(tx_vld), 0, "R2 still silent");
    chk(wiper_flat, w_save, "R2 wipers untouched");
    p_stop();

    // R9: data byte after address byte without repeated START
    p_start();
    send_byte(WR_ADDR, 1'b1, "R2 write addr ack");
    send_byte(8'h09, 1'b1, "R3 address byte ack");
    send_byte(8'h0E, 1'b0, "R9 extra byte not acked");
    chk(32'(tx_vld), 0, "R9 no stream");
    p_stop();
    p_start();
    send_byte(RD_ADDR, 1'b1, "R4 cur-read ack");
    chk(32'(tx_data), 32'(dr_m[1][2]), "R9 pointer from address byte");
    check_wipers(2, "R7 move bank2");
    m_ack(1'b0);
    chk(32'(tx_data), 32'(dr_m[2][2]), "R5 step after ack");
    // R10: STOP mid-stream
    p_stop();
    chk(32'(tx_vld), 0, "R10 stop mid-stream");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule